// File: doc/BRIEF.md
# Sound-Processor Address Decoder

This block sits between a small audio processor core and its local storage. It turns each 16-bit bus access into a RAM access, a boot-ROM access or a register access. Three rules govern it. The 64-byte boot ROM at the top of the address space is seen by reads only. Every write, including a write into the register page 0x00F0-0x00FF, is also sent to RAM. A test/speed register can block RAM writes, or force every RAM read to a fixed pattern.

Inside the register page the block holds the following:
- the test/speed fields;
- the boot-ROM enable bit of the control register;
- two scratch bytes;
- an index/data window onto a 128-entry by 8-bit signal-processor register file.

The mailbox ports and the timer registers belong to neighbouring blocks. This block gives them one-cycle strobes and passes their read data through its read multiplexer.

Reads are combinational in the same cycle as `re`. Writes take effect at the rising clock edge that ends the cycle in which `we` is high. The RAM has 2^RAM_AW bytes and is addressed by `addr` modulo 2^RAM_AW. With the default of 11 address bits, 0x08F8 and 0x00F8 therefore name the same RAM byte.

Top module: `sound_bus_decoder`

## Requirements
- R1: After reset the test register holds 0x02 and the boot ROM overlay is on. With 0x02, RAM is writable and not disabled, and all other test fields are 0. The window index reads 0x00.
- R2: When the overlay is on, a read of 0xFFC0-0xFFFF returns ROM byte i = addr[5:0], whose value is (i*37 + 11) mod 256. For example, 0xFFC0 gives 0x0B and 0xFFFF gives 0x26.
- R3: A write to 0xFFC0-0xFFFF goes to RAM even while the overlay is on. The byte becomes visible once the overlay is turned off.
- R4: While the RAM-disable bit (test bit 2) is 1, every read served by RAM returns 0x5A.
- R5: A RAM write commits only if RAM-writable (test bit 1) is 1 and RAM-disable is 0. These are the values held before the write's own clock edge.
- R6: A write to a register-page address also writes the RAM byte at that address, under the R5 gating. That byte can be read through its alias address.
- R7: A write to 0x00F0 loads the test fields while p_flag is 0. The fields are clk_speed = bits 7:6, tmr_speed = bits 5:4, timers enable = bit 3, RAM-disable = bit 2, RAM-writable = bit 1 and timers disable = bit 0. The write is ignored while p_flag is 1.
- R8: Reads of 0x00F0, 0x00F1 and 0x00FA-0x00FC return 0x00. Reads of 0x00F4-0x00F7 return mbox_rdata, and reads of 0x00FD-0x00FF return tmr_rdata.
- R9: A write to 0x00F1 sets the overlay enable from data bit 7 and pulses ctl_wr for that cycle.
- R10: 0x00F2 is a read/write window index. A read of 0x00F3 returns register file entry (index & 0x7F). A write to 0x00F3 is dropped when index bit 7 is 1.
- R11: 0x00F8 and 0x00F9 are scratch bytes. They return the last value written to them, whatever RAM holds at those addresses.
- R12: The strobes are combinational. tmr_tgt_wr[k] is high for a write to 0x00FA+k, and tmr_out_rd[k] for a read of 0x00FD+k. mbox_rd and mbox_wr are high for a read or write of 0x00F4-0x00F7.
- R13: While re is 0, rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write request, commits at the next rising edge |
| re | input | 1 | Read request, rdata valid in the same cycle |
| p_flag | input | 1 | Core status flag that locks the test register |
| mbox_rdata | input | 8 | Read data from the mailbox neighbour |
| tmr_rdata | input | 8 | Read data from the timer neighbour |
| rdata | output | 8 | Read data |
| clk_speed | output | 2 | Test field: clock speed |
| tmr_speed | output | 2 | Test field: timer speed |
| tmrs_en | output | 1 | Test field: timers enable |
| tmrs_dis | output | 1 | Test field: timers disable |
| ctl_wr | output | 1 | Control register write strobe (wdata carries the bits) |
| mbox_rd | output | 1 | Mailbox read strobe (port = addr[1:0]) |
| mbox_wr | output | 1 | Mailbox write strobe (port = addr[1:0]) |
| tmr_tgt_wr | output | 3 | One-hot timer target write strobes |
| tmr_out_rd | output | 3 | One-hot timer counter read strobes |

## Verification
The assertions assume that `we` and `re` are never high in the same cycle. They also assume that addr, wdata and p_flag change only away from the rising edge. Under these assumptions a read reflects every write that has already committed, and nothing more. The bench keeps to this by driving one access per cycle on the falling edge and sampling a few nanoseconds later. It sets p_flag only between accesses. Before each read of a RAM location it writes that location first, so no check depends on the unreset contents of RAM or of the register file.

// File: rtl/snd_dec_pkg.sv
package snd_dec_pkg;

  // register page occupies addresses whose upper 12 bits equal this value
  localparam logic [11:0] REG_PAGE = 12'h00F;

  // low-nibble selectors within the register page
  localparam logic [3:0] SEL_TEST  = 4'h0;
  localparam logic [3:0] SEL_CTRL  = 4'h1;
  localparam logic [3:0] SEL_WIDX  = 4'h2;
  localparam logic [3:0] SEL_WDAT  = 4'h3;
  localparam logic [3:0] SEL_SCR0  = 4'h8;
  localparam logic [3:0] SEL_SCR1  = 4'h9;
  localparam logic [3:0] SEL_TTGT0 = 4'hA;
  localparam logic [3:0] SEL_TOUT0 = 4'hD;

  localparam int NUM_TIMERS = 3;
  localparam logic [7:0] DISABLED_PATTERN = 8'h5A;

  // bit order matches the decode of the test register
  typedef struct packed {
    logic [1:0] clk_speed;
    logic [1:0] tmr_speed;
    logic       tmrs_en;
    logic       ram_off;
    logic       ram_wr;
    logic       tmrs_dis;
  } test_reg_t;

  localparam test_reg_t TEST_RESET = 8'h02;

  function automatic logic [7:0] boot_rom_byte(input logic [5:0] idx);
    logic [7:0] wide;
    wide = {2'b00, idx} * 8'd37;
    return wide + 8'd11;
  endfunction

  function automatic logic in_reg_page(input logic [15:0] a);
    return a[15:4] == REG_PAGE;
  endfunction

endpackage

// File: rtl/snd_ram.sv
module snd_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          commit,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (commit) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/snd_boot_rom.sv
module snd_boot_rom #(
  parameter int AW = 6
) (
  input  logic [AW-1:0] idx,
  output logic [7:0]    data
);
  import snd_dec_pkg::*;
  localparam int DEPTH = 1 << AW;

  logic [7:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = boot_rom_byte(6'(g));
  end

  assign data = rom[idx];

endmodule

// File: rtl/snd_win.sv
module snd_win #(
  parameter int IW = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        idx_wr,
  input  logic        dat_wr,
  input  logic [7:0]  wdata,
  output logic [IW:0] win_idx,
  output logic [7:0]  win_data
);
  localparam int DEPTH = 1 << IW;

  logic [7:0]  regs [DEPTH];
  logic [IW:0] idx_q;
  logic        rf_we;

  assign rf_we = dat_wr & ~idx_q[IW];

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (idx_wr) idx_q <= wdata[IW:0];
  end

  always_ff @(posedge clk) begin
    if (rf_we) regs[idx_q[IW-1:0]] <= wdata;
  end

  assign win_idx  = idx_q;
  assign win_data = regs[idx_q[IW-1:0]];

  // R10: the upper half of the index space is a read-only mirror
  a_r10_upper_ro: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && idx_q[IW] && !idx_wr) |=> win_data == $past(win_data));

  a_r10_lower_store: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && !idx_q[IW] && !idx_wr) |=> win_data == $past(wdata));

endmodule

// File: rtl/snd_ctl_regs.sv
module snd_ctl_regs (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   test_wr,
  input  logic                   ctrl_wr,
  input  logic [1:0]             scr_wr,
  input  logic                   p_flag,
  input  logic [7:0]             wdata,
  output snd_dec_pkg::test_reg_t test_q,
  output logic                   rom_en,
  output logic [7:0]             scr0,
  output logic [7:0]             scr1
);
  import snd_dec_pkg::*;

  logic test_load;
  assign test_load = test_wr & ~p_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      test_q <= TEST_RESET;
      rom_en <= 1'b1;
      scr0   <= '0;
      scr1   <= '0;
    end else begin
      if (test_load) test_q <= test_reg_t'(wdata);
      if (ctrl_wr)   rom_en <= wdata[7];
      if (scr_wr[0]) scr0   <= wdata;
      if (scr_wr[1]) scr1   <= wdata;
    end
  end

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (rom_en && test_q == TEST_RESET && scr0 == 8'h00));

  // R7: the lock flag freezes the test register
  a_r7_p_lock: assert property (@(posedge clk) disable iff (rst)
    (test_wr && p_flag) |=> $stable(test_q));

  // R9: overlay enable follows data bit 7
  a_r9_rom_bit: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> rom_en == $past(wdata[7]));

  // R11: scratch bytes hold what was written
  a_r11_scratch: assert property (@(posedge clk) disable iff (rst)
    scr_wr[0] |=> scr0 == $past(wdata));

endmodule

// File: rtl/sound_bus_decoder.sv
module sound_bus_decoder #(
  parameter int RAM_AW = 11,
  parameter int ROM_AW = 6,
  parameter int WIN_IW = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        we,
  input  logic        re,
  input  logic        p_flag,
  input  logic [7:0]  mbox_rdata,
  input  logic [7:0]  tmr_rdata,
  output logic [7:0]  rdata,
  output logic [1:0]  clk_speed,
  output logic [1:0]  tmr_speed,
  output logic        tmrs_en,
  output logic        tmrs_dis,
  output logic        ctl_wr,
  output logic        mbox_rd,
  output logic        mbox_wr,
  output logic [2:0]  tmr_tgt_wr,
  output logic [2:0]  tmr_out_rd
);
  import snd_dec_pkg::*;

  // ---------------- decode ----------------
  logic       page_hit;
  logic [3:0] sel;
  logic       rom_hit;
  logic       page_wr;
  logic       page_rd;

  assign page_hit = in_reg_page(addr);
  assign sel      = addr[3:0];
  assign rom_hit  = &addr[15:ROM_AW];
  assign page_wr  = we & page_hit;
  assign page_rd  = re & page_hit;

  logic test_wr, ctrl_wr, idx_wr, dat_wr;
  logic [1:0] scr_wr;

  assign test_wr   = page_wr & (sel == SEL_TEST);
  assign ctrl_wr   = page_wr & (sel == SEL_CTRL);
  assign idx_wr    = page_wr & (sel == SEL_WIDX);
  assign dat_wr    = page_wr & (sel == SEL_WDAT);
  assign scr_wr[0] = page_wr & (sel == SEL_SCR0);
  assign scr_wr[1] = page_wr & (sel == SEL_SCR1);

  assign ctl_wr  = ctrl_wr;
  assign mbox_rd = page_rd & (sel[3:2] == 2'b01);
  assign mbox_wr = page_wr & (sel[3:2] == 2'b01);

  for (genvar k = 0; k < NUM_TIMERS; k++) begin : g_tmr
    assign tmr_tgt_wr[k] = page_wr & (sel == SEL_TTGT0 + 4'(k));
    assign tmr_out_rd[k] = page_rd & (sel == SEL_TOUT0 + 4'(k));
  end

  // ---------------- state ----------------
  test_reg_t  test_q;
  logic       rom_en;
  logic [7:0] scr0, scr1;

  snd_ctl_regs u_ctl (
    .clk     (clk),
    .rst     (rst),
    .test_wr (test_wr),
    .ctrl_wr (ctrl_wr),
    .scr_wr  (scr_wr),
    .p_flag  (p_flag),
    .wdata   (wdata),
    .test_q  (test_q),
    .rom_en  (rom_en),
    .scr0    (scr0),
    .scr1    (scr1)
  );

  assign clk_speed = test_q.clk_speed;
  assign tmr_speed = test_q.tmr_speed;
  assign tmrs_en   = test_q.tmrs_en;
  assign tmrs_dis  = test_q.tmrs_dis;

  logic [WIN_IW:0] win_idx;
  logic [7:0]      win_data;

  snd_win #(.IW(WIN_IW)) u_win (
    .clk      (clk),
    .rst      (rst),
    .idx_wr   (idx_wr),
    .dat_wr   (dat_wr),
    .wdata    (wdata),
    .win_idx  (win_idx),
    .win_data (win_data)
  );

  // every write also lands in RAM, under the writable / disable gating
  logic       ram_commit;
  logic [7:0] ram_rdata;

  assign ram_commit = we & test_q.ram_wr & ~test_q.ram_off;

  snd_ram #(.AW(RAM_AW)) u_ram (
    .clk    (clk),
    .commit (ram_commit),
    .waddr  (addr[RAM_AW-1:0]),
    .wdata  (wdata),
    .raddr  (addr[RAM_AW-1:0]),
    .rdata  (ram_rdata)
  );

  logic [7:0] rom_data;

  snd_boot_rom #(.AW(ROM_AW)) u_rom (
    .idx  (addr[ROM_AW-1:0]),
    .data (rom_data)
  );

  // ---------------- read mux ----------------
  logic [7:0] page_data;

  always_comb begin
    page_data = 8'h00;
    unique case (sel)
      SEL_WIDX:                      page_data = 8'(win_idx);
      SEL_WDAT:                      page_data = win_data;
      4'h4, 4'h5, 4'h6, 4'h7:        page_data = mbox_rdata;
      SEL_SCR0:                      page_data = scr0;
      SEL_SCR1:                      page_data = scr1;
      4'hD, 4'hE, 4'hF:              page_data = tmr_rdata;
      default:                       page_data = 8'h00;
    endcase
  end

  always_comb begin
    if (!re)                  rdata = 8'h00;
    else if (page_hit)        rdata = page_data;
    else if (rom_hit && rom_en) rdata = rom_data;
    else if (test_q.ram_off)  rdata = DISABLED_PATTERN;
    else                      rdata = ram_rdata;
  end

  // ---------------- assertions ----------------
  // R2: overlay returns the computed ROM byte
  a_r2_rom_overlay: assert property (@(posedge clk) disable iff (rst)
    (re && rom_hit && rom_en) |-> rdata == boot_rom_byte(addr[5:0]));

  // R4: disabled RAM reads give the fixed pattern
  a_r4_fixed_pattern: assert property (@(posedge clk) disable iff (rst)
    (re && !page_hit && !(rom_hit && rom_en) && test_q.ram_off) |-> rdata == 8'h5A);

  // R5: no RAM commit while disabled or not writable
  a_r5_gate: assert property (@(posedge clk) disable iff (rst)
    ram_commit |-> (test_q.ram_wr && !test_q.ram_off));

  // R8: write-only registers read as zero
  a_r8_wo_zero: assert property (@(posedge clk) disable iff (rst)
    (page_rd && (sel == 4'h0 || sel == 4'h1 || sel == 4'hA || sel == 4'hB || sel == 4'hC))
      |-> rdata == 8'h00);

  // R12: timer strobes are one-hot
  a_r12_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tmr_tgt_wr) && $onehot0(tmr_out_rd));

  // R13: idle read data is zero
  a_r13_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !re |-> rdata == 8'h00);

endmodule

// File: tb/tb_sound_bus_decoder.sv
module tb_sound_bus_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic        p_flag = 1'b0;
  logic [7:0]  mbox_rdata = 8'h3C;
  logic [7:0]  tmr_rdata = 8'h07;
  logic [7:0]  rdata;
  logic [1:0]  clk_speed, tmr_speed;
  logic        tmrs_en, tmrs_dis, ctl_wr, mbox_rd, mbox_wr;
  logic [2:0]  tmr_tgt_wr, tmr_out_rd;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  sound_bus_decoder dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .p_flag(p_flag), .mbox_rdata(mbox_rdata), .tmr_rdata(tmr_rdata),
    .rdata(rdata), .clk_speed(clk_speed), .tmr_speed(tmr_speed),
    .tmrs_en(tmrs_en), .tmrs_dis(tmrs_dis), .ctl_wr(ctl_wr),
    .mbox_rd(mbox_rd), .mbox_wr(mbox_wr), .tmr_tgt_wr(tmr_tgt_wr),
    .tmr_out_rd(tmr_out_rd)
  );

  // op: 1 = write, 2 = read and compare; fields {op, addr, data, req}
  localparam int NV = 46;
  localparam logic [35:0] VEC [NV] = '{
    36'h2_00F2_00_01, // R1 window index resets to 0
    36'h2_FFC0_0B_01, // R1/R2 overlay on after reset
    36'h2_FFFF_26_02, // R2 last ROM byte
    36'h1_0100_A1_05, // R5 normal write
    36'h2_0100_A1_05,
    36'h1_FFC0_77_03, // R3 write under overlay
    36'h2_FFC0_0B_03,
    36'h1_00F1_00_09, // R9 overlay off
    36'h2_FFC0_77_03,
    36'h2_07C0_77_03, // R3 same byte via alias
    36'h1_00F8_99_0B, // R11
    36'h2_00F8_99_0B,
    36'h2_08F8_99_06, // R6 register write reached RAM
    36'h1_08F8_12_06,
    36'h2_00F8_99_0B, // R11 independent of RAM
    36'h2_08F8_12_06,
    36'h2_00F0_00_08, // R8
    36'h2_00F1_00_08,
    36'h2_00FA_00_08,
    36'h2_00FB_00_08,
    36'h2_00FC_00_08,
    36'h2_00F4_3C_08,
    36'h2_00FD_07_08,
    36'h1_00F2_05_0A, // R10 window
    36'h1_00F3_44_0A,
    36'h2_00F3_44_0A,
    36'h2_00F2_05_0A,
    36'h1_00F2_85_0A,
    36'h2_00F3_44_0A, // mirror
    36'h1_00F3_55_0A, // dropped
    36'h1_00F2_05_0A,
    36'h2_00F3_44_0A,
    36'h1_00F0_06_04, // R4 disable
    36'h2_0100_5A_04,
    36'h2_FFC0_5A_04,
    36'h1_0100_EE_05, // R5 blocked by disable
    36'h1_00F0_02_05,
    36'h2_0100_A1_05,
    36'h1_00F0_00_05, // R5 not writable
    36'h1_0100_33_05,
    36'h1_00F0_02_05,
    36'h2_0100_A1_05,
    36'h2_08F0_00_06, // R6 gated register writes
    36'h2_08F2_05_06,
    36'h1_00F1_80_09, // R9 overlay back on
    36'h2_FFC0_0B_09
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; re = 1'b0;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input logic [7:0] exp, input int req);
    @(negedge clk);
    addr = a; we = 1'b0; re = 1'b1;
    #3;
    chk(rdata, exp, req, $sformatf("read %04h", a));
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: test fields after reset
    #3;
    chk({clk_speed, tmr_speed, tmrs_en, tmrs_dis}, 8'h00, 1, "test fields at reset");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35:32] == 4'h1) do_write(VEC[i][31:16], VEC[i][15:8]);
      else do_read(VEC[i][31:16], VEC[i][15:8], int'(VEC[i][7:0]));
    end

    // R7: lock flag ignores a test write
    @(negedge clk); p_flag = 1'b1;
    do_write(16'h00F0, 8'hFF);
    @(negedge clk); p_flag = 1'b0; #3;
    chk({clk_speed, tmr_speed, tmrs_en, tmrs_dis}, 8'h00, 7, "locked test write");
    do_read(16'h0100, 8'hA1, 7);
    // R7: field decode
    do_write(16'h00F0, 8'h5A);
    #3;
    chk({2'b00, clk_speed, tmr_speed, tmrs_en, tmrs_dis}, 8'h16, 7, "decode 5A");
    do_write(16'h00F0, 8'hB3);
    #3;
    chk({2'b00, clk_speed, tmr_speed, tmrs_en, tmrs_dis}, 8'h2D, 7, "decode B3");
    do_read(16'h0100, 8'hA1, 7);

    // R9 / R12: strobes during the access cycle
    @(negedge clk); addr = 16'h00F1; wdata = 8'h80; we = 1'b1; #3;
    chk({7'b0, ctl_wr}, 8'h01, 9, "ctl_wr strobe");
    @(negedge clk); addr = 16'h00FB; #3;
    chk({5'b0, tmr_tgt_wr}, 8'h02, 12, "tmr_tgt_wr FB");
    @(negedge clk); addr = 16'h00F5; #3;
    chk({6'b0, mbox_wr, mbox_rd}, 8'h02, 12, "mbox_wr F5");
    @(negedge clk); we = 1'b0; re = 1'b1; addr = 16'h00FE; #3;
    chk({5'b0, tmr_out_rd}, 8'h02, 12, "tmr_out_rd FE");
    chk(rdata, 8'h07, 8, "timer data pass-through");
    @(negedge clk); addr = 16'h00F6; #3;
    chk({6'b0, mbox_wr, mbox_rd}, 8'h01, 12, "mbox_rd F6");
    @(negedge clk); addr = 16'h0100; #3;
    chk({5'b0, tmr_out_rd}, 8'h00, 12, "no strobe outside page");

    // R13: idle read data
    @(negedge clk); re = 1'b0; addr = 16'hFFC0; #3;
    chk(rdata, 8'h00, 13, "idle rdata");

    finish_run();
  end

endmodule